// File: doc/BRIEF.md
# Burst Read Transfer Sequencer

This block runs the read side of a bus master for a single operand taken from a memory port. The port may be narrower than the operand. A start request captures five things: the start address, the operand size (byte, word, longword or 16-byte line), the port width, a per-region burst-enable flag and a flag that marks a DRAM region. From these the block chooses between a burst and a series of separate burst-inhibited transfers, and it works out how many beats the operand needs.

For each beat the block drives the full address and a 2-bit size code, and marks the cycles that open an address phase. It moves to the next beat only when the ready input is high. A done pulse marks the accepted final beat. In the cycle after that pulse the block is idle again and will take the next request.

Top module: `burst_rd_seq`

## Requirements
- R1: Operand code: 0 = longword (4 bytes), 1 = byte, 2 = word, 3 = line (16 bytes). Port code: 1 = 8-bit, 2 = 16-bit, 0 or 3 = 32-bit. burst_o is high for the whole sequence exactly when the operand byte count exceeds the port byte count and burst_en_i or dram_i was set at the start.
- R2: A DRAM region (dram_i = 1) bursts whenever the operand is wider than the port, whatever the value of burst_en_i.
- R3: In a burst, and in any single-beat access, size_o carries the operand code for every beat, whatever the port width. size_o and burst_o do not change during a sequence.
- R4: In burst-inhibited mode (operand wider than port, burst_en_i = 0, dram_i = 0), every beat is its own transfer. tstart_o is high in the first cycle of each beat. size_o carries the code of one port-width transfer: 1 for an 8-bit port, 2 for a 16-bit port, 0 for a 32-bit port.
- R5: In a burst, tstart_o is high only in the first cycle of the first beat.
- R6: The sequence holds max(1, operand bytes / port bytes) beats, so between 2 and 16 beats when bursting.
- R7: Beat k address: the start address is first aligned to min(operand bytes, 4). The low log2(operand bytes) bits then take the value (aligned low bits + k x port bytes) modulo the operand byte count. All other bits keep the aligned start value, so a line read wraps inside its 16-byte line.
- R8: A beat advances only on a clock edge where ready_i is high. While ready_i is low, busy_o, addr_o and size_o hold their values.
- R9: done_o is high in the cycle where ready_i is high on the final beat. busy_o is low in the next cycle, and a start in that cycle is accepted.
- R10: start_i and every request input are ignored while busy_o is high. The running sequence keeps its captured address, sizes and flags.
- R11: During reset and while idle, busy_o, done_o, tstart_o and burst_o are 0, and addr_o and size_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a read; taken when idle |
| addr_i | input | ADDR_W | Start address |
| opsz_i | input | 2 | Operand size code |
| port_i | input | 2 | Port width code |
| burst_en_i | input | 1 | Region allows bursts |
| dram_i | input | 1 | Region is DRAM |
| ready_i | input | 1 | Current beat is accepted |
| busy_o | output | 1 | Sequence in progress |
| addr_o | output | ADDR_W | Address of the current beat |
| size_o | output | 2 | Size code of the current transfer |
| burst_o | output | 1 | Sequence runs in burst mode |
| tstart_o | output | 1 | First cycle of an address phase |
| done_o | output | 1 | Final beat accepted |

## Verification
The bench builds the block with ADDR_W = 12. At that width the 8 upper address bits can change between sequences while the 4 line-offset bits are swept exhaustively. The bench crosses every operand code, every port code including the duplicate 32-bit code, both burst-enable values, both DRAM values and all 16 start offsets. That reaches every beat count from 1 to 16, every line wrap position and the misaligned-start cases. Ready stalls follow a rotating pattern. In half of the sequences the request inputs are scrambled and start is held high while busy.

// File: rtl/brs_pkg.sv
package brs_pkg;
  localparam int LINE_BYTES = 16;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int BEAT_W     = $clog2(LINE_BYTES);

  typedef enum logic [1:0] {
    SZ_LONG = 2'd0,
    SZ_BYTE = 2'd1,
    SZ_WORD = 2'd2,
    SZ_LINE = 2'd3
  } size_e;

  function automatic logic [4:0] op_bytes(input logic [1:0] c);
    case (c)
      2'd1:    return 5'd1;
      2'd2:    return 5'd2;
      2'd3:    return 5'd16;
      default: return 5'd4;
    endcase
  endfunction

  function automatic logic [1:0] port_shift(input logic [1:0] c);
    case (c)
      2'd1:    return 2'd0;
      2'd2:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  // size code of one port-wide transfer
  function automatic logic [1:0] port_code(input logic [1:0] c);
    return (c == 2'd3) ? 2'd0 : c;
  endfunction
endpackage

// File: rtl/brs_mode_dec.sv
module brs_mode_dec
  import brs_pkg::*;
(
  input  logic [1:0]        op_i,
  input  logic [1:0]        port_i,
  input  logic              burst_en_i,
  input  logic              dram_i,
  output logic              burst_o,
  output logic [BEAT_W-1:0] last_idx_o,
  output logic [1:0]        size_o,
  output logic [1:0]        step_sh_o,
  output logic [OFF_W-1:0]  wrap_mask_o,
  output logic [OFF_W-1:0]  align_mask_o
);
  logic [4:0] ob;
  logic [4:0] pb;
  logic [4:0] nbeats;
  logic       wide;

  always_comb begin
    ob           = op_bytes(op_i);
    step_sh_o    = port_shift(port_i);
    pb           = 5'd1 << step_sh_o;
    wide         = ob > pb;
    nbeats       = wide ? (ob >> step_sh_o) : 5'd1;
    last_idx_o   = BEAT_W'(nbeats - 5'd1);
    burst_o      = wide && (burst_en_i || dram_i);
    size_o       = (burst_o || !wide) ? op_i : port_code(port_i);
    wrap_mask_o  = OFF_W'(ob - 5'd1);
    align_mask_o = (ob >= 5'd4) ? OFF_W'(3) : OFF_W'(ob - 5'd1);
  end
endmodule

// File: rtl/brs_beat_ctr.sv
module brs_beat_ctr #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         adv_i,
  input  logic [W-1:0] last_idx_i,
  output logic [W-1:0] idx_o,
  output logic         last_o,
  output logic         first_cyc_o
);
  logic [W-1:0] idx_q;
  logic         first_q;

  assign idx_o       = idx_q;
  assign last_o      = idx_q == last_idx_i;
  assign first_cyc_o = first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      first_q <= 1'b0;
    end else begin
      first_q <= load_i || (adv_i && !last_o);
      if (load_i)                idx_q <= '0;
      else if (adv_i && !last_o) idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/brs_addr_gen.sv
module brs_addr_gen
  import brs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [BEAT_W-1:0] idx_i,
  input  logic [1:0]        step_sh_i,
  input  logic [OFF_W-1:0]  wrap_mask_i,
  input  logic [OFF_W-1:0]  align_mask_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [OFF_W-1:0] off;
  logic [OFF_W-1:0] lo_al;
  logic [OFF_W-1:0] lo;

  always_comb begin
    off    = OFF_W'(idx_i) << step_sh_i;
    lo_al  = base_i[OFF_W-1:0] & ~align_mask_i;
    lo     = (lo_al & ~wrap_mask_i) | ((lo_al + off) & wrap_mask_i);
    addr_o = {base_i[ADDR_W-1:OFF_W], lo};
  end
endmodule

// File: rtl/burst_rd_seq.sv
module burst_rd_seq
  import brs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        opsz_i,
  input  logic [1:0]        port_i,
  input  logic              burst_en_i,
  input  logic              dram_i,
  input  logic              ready_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        size_o,
  output logic              burst_o,
  output logic              tstart_o,
  output logic              done_o
);
  logic              busy_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        op_q;
  logic [1:0]        port_q;
  logic              en_q;
  logic              dram_q;

  logic              accept;
  logic              adv;
  logic              burst;
  logic [BEAT_W-1:0] last_idx;
  logic [1:0]        size;
  logic [1:0]        step_sh;
  logic [OFF_W-1:0]  wrap_mask;
  logic [OFF_W-1:0]  align_mask;
  logic [BEAT_W-1:0] idx;
  logic              last;
  logic              first_cyc;
  logic [ADDR_W-1:0] beat_addr;

  assign accept = start_i && !busy_q;
  assign adv    = busy_q && ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      base_q <= '0;
      op_q   <= '0;
      port_q <= '0;
      en_q   <= 1'b0;
      dram_q <= 1'b0;
    end else if (accept) begin
      busy_q <= 1'b1;
      base_q <= addr_i;
      op_q   <= opsz_i;
      port_q <= port_i;
      en_q   <= burst_en_i;
      dram_q <= dram_i;
    end else if (adv && last) begin
      busy_q <= 1'b0;
    end
  end

  brs_mode_dec u_dec (
    .op_i        (op_q),
    .port_i      (port_q),
    .burst_en_i  (en_q),
    .dram_i      (dram_q),
    .burst_o     (burst),
    .last_idx_o  (last_idx),
    .size_o      (size),
    .step_sh_o   (step_sh),
    .wrap_mask_o (wrap_mask),
    .align_mask_o(align_mask)
  );

  brs_beat_ctr #(.W(BEAT_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .adv_i      (adv),
    .last_idx_i (last_idx),
    .idx_o      (idx),
    .last_o     (last),
    .first_cyc_o(first_cyc)
  );

  brs_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .base_i      (base_q),
    .idx_i       (idx),
    .step_sh_i   (step_sh),
    .wrap_mask_i (wrap_mask),
    .align_mask_i(align_mask),
    .addr_o      (beat_addr)
  );

  assign busy_o   = busy_q;
  assign addr_o   = busy_q ? beat_addr : '0;
  assign size_o   = busy_q ? size : 2'd0;
  assign burst_o  = busy_q && burst;
  assign tstart_o = busy_q && first_cyc && (!burst || idx == '0);
  assign done_o   = adv && last;
endmodule

// File: rtl/brs_chk.sv
module brs_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_i,
  input logic              busy_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [1:0]        size_o,
  input logic              burst_o,
  input logic              tstart_o,
  input logic              done_o
);
  AST_WAIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !ready_i |=> busy_o && $stable(addr_o) && $stable(size_o)); // R8
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o && !done_o); // R9
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o); // R10
  AST_BURST_ONE_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && burst_o && $past(busy_o) |-> !tstart_o); // R5
  AST_INHIBIT_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !burst_o && !$past(busy_o) |-> tstart_o); // R4
  AST_SIZE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(size_o) && $stable(burst_o)); // R3
  AST_LINE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> addr_o[ADDR_W-1:4] == $past(addr_o[ADDR_W-1:4])); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !tstart_o && !done_o && !burst_o); // R11
endmodule

bind burst_rd_seq brs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ready_i (ready_i),
  .busy_o  (busy_o),
  .addr_o  (addr_o),
  .size_o  (size_o),
  .burst_o (burst_o),
  .tstart_o(tstart_o),
  .done_o  (done_o)
);

// File: tb/burst_rd_seq_bench.sv
`timescale 1ns/1ps
module burst_rd_seq_bench;
  localparam int AW = 12;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [1:0]    opsz_i = '0;
  logic [1:0]    port_i = '0;
  logic          burst_en_i = 1'b0;
  logic          dram_i = 1'b0;
  logic          ready_i = 1'b0;
  logic          busy_o;
  logic [AW-1:0] addr_o;
  logic [1:0]    size_o;
  logic          burst_o;
  logic          tstart_o;
  logic          done_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk_i = ~clk_i;

  burst_rd_seq #(.ADDR_W(AW)) u_burst_rd_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .addr_i(addr_i),
    .opsz_i(opsz_i), .port_i(port_i), .burst_en_i(burst_en_i), .dram_i(dram_i),
    .ready_i(ready_i), .busy_o(busy_o), .addr_o(addr_o), .size_o(size_o),
    .burst_o(burst_o), .tstart_o(tstart_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int obytes(input int c);
    return (c == 1) ? 1 : (c == 2) ? 2 : (c == 3) ? 16 : 4;
  endfunction
  function automatic int pbytes(input int c);
    return (c == 1) ? 1 : (c == 2) ? 2 : 4;
  endfunction

  task automatic check_idle(input string req);
    chk(busy_o == 1'b0, req, busy_o, 0);
    chk(done_o == 1'b0 && tstart_o == 1'b0 && burst_o == 1'b0, req,
        {done_o, tstart_o, burst_o}, 0);
    chk(addr_o == '0 && size_o == 2'd0, req, addr_o, 0);
  endtask

  task automatic run_seq(input int seq, input int op, input int pt, input int en,
                         input int dr, input int start_a, input bit scramble);
    int ob, pb, nb, al, lo_al, wm, exp_a, exp_sz, k, w;
    bit bexp, wide, exp_ts;
    ob    = obytes(op);
    pb    = pbytes(pt);
    wide  = ob > pb;
    nb    = wide ? ob / pb : 1;
    bexp  = wide && (en != 0 || dr != 0);
    exp_sz = (bexp || !wide) ? op : ((pt == 3) ? 0 : pt);
    al    = (ob >= 4) ? 3 : ob - 1;
    al    = start_a & ~al;
    lo_al = al % 16;
    wm    = ob - 1;

    start_i    = 1'b1;
    addr_i     = AW'(start_a);
    opsz_i     = 2'(op);
    port_i     = 2'(pt);
    burst_en_i = en[0];
    dram_i     = dr[0];
    ready_i    = 1'b0;
    @(negedge clk_i);
    start_i = scramble;
    if (scramble) begin
      addr_i     = ~addr_i;
      opsz_i     = ~opsz_i;
      port_i     = port_i + 2'd1;
      burst_en_i = ~burst_en_i;
      dram_i     = ~dram_i;
    end
    k = 0;
    w = 0;
    forever begin
      ready_i = ((seq * 7 + k * 3 + w) % 5) != 0;
      #1;
      exp_a  = (al - lo_al) + ((lo_al & ~wm) | ((lo_al + k * pb) & wm));
      exp_ts = (w == 0) && (!bexp || k == 0);
      chk(busy_o == 1'b1, scramble ? "R10 busy" : "R8 busy", busy_o, 1);
      chk(int'(addr_o) == exp_a, scramble ? "R10 addr" : "R7 addr", addr_o, exp_a);
      chk(burst_o == bexp, dr != 0 ? "R2 burst" : "R1 burst", burst_o, bexp);
      chk(int'(size_o) == exp_sz, bexp ? "R3 size" : "R4 size", size_o, exp_sz);
      chk(tstart_o == exp_ts, bexp ? "R5 tstart" : "R4 tstart", tstart_o, exp_ts);
      chk(done_o == (ready_i && k == nb - 1), "R6 done/beat count", done_o,
          ready_i && k == nb - 1);
      if (ready_i) begin
        if (k == nb - 1) break;
        k++;
        w = 0;
      end else begin
        w++;
      end
      @(negedge clk_i);
    end
    @(negedge clk_i);
    start_i = 1'b0;
    ready_i = 1'b0;
    #1;
    check_idle("R9 idle after done");
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 150000) begin
        n_bad++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    int seq;
    seq = 0;
    repeat (3) @(negedge clk_i);
    start_i = 1'b1;
    #1;
    check_idle("R11 reset");
    @(negedge clk_i);
    start_i = 1'b0;
    rst_ni  = 1'b1;
    @(negedge clk_i);
    #1;
    check_idle("R11 idle");
    for (int op = 0; op < 4; op++)
      for (int pt = 0; pt < 4; pt++)
        for (int en = 0; en < 2; en++)
          for (int dr = 0; dr < 2; dr++)
            for (int lo = 0; lo < 16; lo++) begin
              @(negedge clk_i);
              run_seq(seq, op, pt, en, dr, ((seq * 37) % 256) * 16 + lo, seq[0]);
              seq++;
            end
    // back-to-back: start in the cycle right after done
    run_seq(seq, 3, 1, 0, 1, 12'h5A6, 1'b0);
    run_seq(seq + 1, 0, 2, 0, 0, 12'h3F3, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule